// File: doc/BRIEF.md
# Serial Shift Engine with Bit Counter

This block is a bare serial shift engine for a small microcontroller. An 8-bit data/shift register and a 4-bit bit counter both advance on each falling edge of an external serial clock line. The serial clock and serial data input are brought into the system clock domain through two-flop synchronisers. Falling edges are detected there, so the serial clock is never used as a real clock. Data leaves most significant bit first. Each shift takes in the serial input at the bottom of the register.

The processor loads the register in parallel and reads it back at any time. When the counter's top bit sets on the eighth falling edge, an interrupt request rises. The counter then holds. A strobe to the interrupt-disable register returns the counter to zero and drops the request, which arms the engine for the next byte. The serial output is modelled for an open-drain pad: an enable that pulls the line low while the outgoing bit is 0. With that pad, serial input and output can share one wire. Clock generation happens elsewhere: a port pin toggled by software, a timer, or an external master.

Top module: `ser_shift_unit`

## Requirements
- R1: After the asynchronous reset `rst_ni` low, the read data is 0x00 and `irq_o` is 0.
- R2: On each detected falling edge of `sclk_i`, the register becomes its low seven bits followed by the synchronised `sdin_i` in bit 0. Over eight edges the bits come in most significant first.
- R3: `sdo_o` always shows bit 7 of the register. After the edge that shifts a bit out, bit 6 moves up to appear there.
- R4: A falling edge of `sclk_i` is seen through a 2-flop synchroniser. The register updates on the third rising edge of `clk_i` after `sclk_i` goes low. A level that is held shorter than 3 `clk_i` cycles is not guaranteed to be seen.
- R5: `irq_o` is bit 3 of the bit counter. It is 0 after seven falling edges and 1 after the eighth.
- R6: Once bit 3 of the counter is set, further falling edges leave the counter and `irq_o` unchanged. The register keeps shifting.
- R7: A pulse on `irq_clr_i` sets the counter to 0 and `irq_o` to 0. This includes a partly counted byte, so eight new edges are needed for the next request.
- R8: A pulse on `data_wr_i` loads `data_wdata_i` into the register. `data_rdata_o` always shows the register.
- R9: When `data_wr_i` and a detected falling edge fall in the same cycle, the parallel load wins and no shift happens.
- R10: When `irq_clr_i` and a detected falling edge fall in the same cycle, the counter ends at 0.
- R11: `sdo_pull_o` (open-drain pull-low enable) is 1 exactly when `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock pin, idle high |
| sdin_i | input | 1 | Serial data input pin |
| data_wr_i | input | 1 | Processor write strobe to the data register |
| data_wdata_i | input | 8 | Processor write data |
| data_rdata_o | output | 8 | Current shift register contents |
| irq_clr_i | input | 1 | Processor write strobe to the interrupt-disable register |
| irq_o | output | 1 | Byte-complete interrupt request |
| sdo_o | output | 1 | Outgoing serial bit (register bit 7) |
| sdo_pull_o | output | 1 | Open-drain enable: pull the pin low |

## Verification
On every cycle, the assertions check the register-level rules. A shift takes in the synchronised input, a load takes the write data, and an idle cycle holds the register. The counter steps by one, holds once bit 3 is set, and clears on the strobe. Only the bench scenarios can show the end-to-end behaviour at the pins: the three-cycle latency from the pin, the order in which a whole byte arrives and leaves, the request rising exactly on the eighth edge, and the outcome when a strobe and an edge land in the same cycle.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LOAD  = 2'd2
  } sh_op_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ser_fall_det.sv
module ser_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // one detected fall per high-to-low transition
  a_r4_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ser_shreg.sv
module ser_shreg
  import ser_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sh_op_e            op_i,
  input  logic              sin_i,
  input  logic [DATA_W-1:0] load_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else begin
      unique case (op_i)
        SH_LOAD:  q_q <= load_i;
        SH_SHIFT: q_q <= {q_q[DATA_W-2:0], sin_i};
        default:  q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SH_SHIFT |=> q_o == {$past(q_o[DATA_W-2:0]), $past(sin_i)});
  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SH_LOAD |=> q_o == $past(load_i));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == SH_HOLD |=> $stable(q_o));
endmodule

// File: rtl/ser_bitcnt.sv
module ser_bitcnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned TopBit = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (step_i && !cnt_q[TopBit]) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = cnt_q[TopBit];

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && !cnt_q[TopBit] |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r6_hold_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[TopBit] && !clr_i |=> $stable(cnt_q));
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0 && !done_o);
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(clr_i));
endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit
  import ser_shift_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] data_rdata_o,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              sdo_o,
  output logic              sdo_pull_o
);
  logic   sclk_s, sdin_s, fall;
  sh_op_e op;
  logic [DATA_W-1:0] shreg;

  // idle-high reset value keeps reset release from looking like a fall
  ser_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sclk_i), .q_o (sclk_s)
  );
  ser_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdin (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sdin_i), .q_o (sdin_s)
  );

  ser_fall_det u_fall (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (sclk_s), .fall_o (fall)
  );

  always_comb begin
    if (data_wr_i) op = SH_LOAD;
    else if (fall) op = SH_SHIFT;
    else           op = SH_HOLD;
  end

  ser_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op),
    .sin_i (sdin_s), .load_i (data_wdata_i), .q_o (shreg)
  );

  ser_bitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .step_i (fall),
    .clr_i (irq_clr_i), .done_o (irq_o)
  );

  assign data_rdata_o = shreg;
  assign sdo_o        = shreg[DATA_W-1];
  assign sdo_pull_o   = ~shreg[DATA_W-1];

  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && fall |=> data_rdata_o == $past(data_wdata_i));
  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && fall |=> !irq_o);
  a_r3_out_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall && !data_wr_i |=> sdo_o == $past(data_rdata_o[DATA_W-2]));
endmodule

// File: tb/ser_shift_unit_bench.sv
module ser_shift_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b1, sdin = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sdo, pull;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  ser_shift_unit u_ser_shift_unit (
    .clk_i (clk), .rst_ni (rst_n), .sclk_i (sclk), .sdin_i (sdin),
    .data_wr_i (wr), .data_wdata_i (wdata), .data_rdata_o (rdata),
    .irq_clr_i (clr), .irq_o (irq), .sdo_o (sdo), .sdo_pull_o (pull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic sclk_edge(input logic b);
    @(negedge clk); sdin = b;
    idle(3);
    sclk = 1'b0;
    idle(5);
    sclk = 1'b1;
    idle(5);
  endtask

  // sends byte, checks outgoing bits against preloaded value
  task automatic send_byte(input logic [7:0] pre, input logic [7:0] inb, input string tag);
    load(pre);
    for (int i = 7; i >= 0; i--) begin
      chk(sdo === pre[i], {tag, " R3 sdo bit"}, int'(sdo), int'(pre[i]));
      chk(pull === ~pre[i], {tag, " R11 pull"}, int'(pull), int'(~pre[i]));
      sclk_edge(inb[i]);
    end
    chk(rdata === inb, {tag, " R2 byte in"}, rdata, inb);
  endtask

  task automatic t_reset();
    chk(rdata === 8'h00, "R1 data", rdata, 0);
    chk(irq === 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_load_read();
    load(8'hA5);
    chk(rdata === 8'hA5, "R8 load", rdata, 8'hA5);
    load(8'h3C);
    chk(rdata === 8'h3C, "R8 reload", rdata, 8'h3C);
  endtask

  task automatic t_latency();
    load(8'h40);
    @(negedge clk); sdin = 1'b1; idle(3);
    sclk = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(rdata === 8'h40, "R4 no update before 3rd edge", rdata, 8'h40);
    @(posedge clk); #1;
    chk(rdata === 8'h81, "R4 update on 3rd edge", rdata, 8'h81);
    idle(4); sclk = 1'b1; idle(5);
    pulse_clr();
  endtask

  task automatic t_irq();
    pulse_clr();
    for (int i = 0; i < 7; i++) sclk_edge(1'b0);
    chk(irq === 1'b0, "R5 no irq after 7", irq, 0);
    sclk_edge(1'b1);
    chk(irq === 1'b1, "R5 irq after 8", irq, 1);
  endtask

  task automatic t_hold();
    load(8'h01);
    for (int i = 0; i < 9; i++) sclk_edge(1'b0);
    chk(irq === 1'b1, "R6 irq held", irq, 1);
    chk(rdata === 8'h00, "R6 still shifts", rdata, 0);
    pulse_clr();
    chk(irq === 1'b0, "R7 clear irq", irq, 0);
  endtask

  task automatic t_clear_partial();
    pulse_clr();
    for (int i = 0; i < 4; i++) sclk_edge(1'b1);
    pulse_clr();
    for (int i = 0; i < 7; i++) sclk_edge(1'b1);
    chk(irq === 1'b0, "R7 partial count cleared", irq, 0);
    sclk_edge(1'b1);
    chk(irq === 1'b1, "R7 eight new edges", irq, 1);
  endtask

  task automatic t_load_priority();
    pulse_clr();
    load(8'hFF);
    @(negedge clk); sdin = 1'b0; idle(3);
    sclk = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr = 1'b1; wdata = 8'h5A;
    @(negedge clk); wr = 1'b0;
    chk(rdata === 8'h5A, "R9 load over shift", rdata, 8'h5A);
    idle(3); sclk = 1'b1; idle(5);
  endtask

  task automatic t_clear_priority();
    pulse_clr();
    for (int i = 0; i < 3; i++) sclk_edge(1'b0);
    @(negedge clk); idle(3);
    sclk = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    idle(3); sclk = 1'b1; idle(5);
    for (int i = 0; i < 7; i++) sclk_edge(1'b0);
    chk(irq === 1'b0, "R10 clear over step", irq, 0);
    sclk_edge(1'b0);
    chk(irq === 1'b1, "R10 then eight edges", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_load_read();
    t_latency();
    pulse_clr();
    send_byte(8'hB2, 8'h6D, "pat1");
    chk(irq === 1'b1, "R5 irq after byte", irq, 1);
    pulse_clr();
    send_byte(8'h0F, 8'hF0, "pat2");
    t_irq();
    t_hold();
    t_clear_partial();
    t_load_priority();
    t_clear_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule